// File: doc/BRIEF.md
# Paired-Byte Capture/Compare Data Register

This block holds one 16-bit timer data word and exposes it to an 8-bit register bus as two byte locations, a low half and a high half. In word mode a write to the high location only fills a staging latch. The following write to the low location moves the staged high byte and the new low byte into the word in one clock edge, so a timer that uses the word never sees half of an update. Reads are staged the same way in the other direction. A low-byte read returns the live low half and, on the same edge, copies the live high half into a hold latch. A later high-byte read returns that held byte.

A split mode lets software write each half on its own, with immediate effect. Reads keep the low-then-high staging in split mode. A mode input picks compare use or capture use. In compare use the word is rewritten by software at any time. In capture use a strobe also loads the word from a 16-bit counter input. A third bus location reads the counter's low byte and holds its high byte in the same hold latch. So a counter read placed inside a data-register read pair disturbs that pair, just as a stray high-byte write disturbs a write pair.

Top module: `ccr_byte_reg`

## Requirements
- R1: After reset the word, the write staging latch and the read hold latch are all zero: `cmp_value` is 0, a high-byte read returns 0, and a low-byte write with no high-byte write before it loads {0, data}.
- R2: In word mode (`split_mode`=0) a write to address 1 (high byte) leaves `cmp_value` unchanged. A write to address 0 (low byte) loads `cmp_value` with {staged high byte, written byte} on that clock edge.
- R3: A high-byte write that is never followed by a low-byte write never changes `cmp_value`, however many cycles pass.
- R4: A read of address 0 returns `cmp_value[7:0]` on `bus_rdata` in the cycle of the read strobe, and on that edge it copies `cmp_value[15:8]` into the hold latch.
- R5: A read of address 1 returns the hold latch, which is the high byte at the most recent low read, even if the word has changed since then.
- R6: A second high-byte write before the completing low-byte write replaces the staged byte, so the word takes the most recent high byte.
- R7: A read of address 2 returns `cnt_value[7:0]` and copies `cnt_value[15:8]` into the same hold latch. A second low read of address 0 also reloads the latch. A later address-1 read returns the most recent of these samples.
- R8: In split mode (`split_mode`=1) a write to address 0 or address 1 replaces only that half of `cmp_value` on that edge and leaves the other half unchanged. It does not touch the write staging latch.
- R9: With `capture_mode`=1, `cap_strobe` loads `cnt_value` into `cmp_value` on that edge. With `capture_mode`=0, `cap_strobe` has no effect.
- R10: When a capture and a word-completing write fall in the same cycle, the capture value is loaded and the write is lost.
- R11: `bus_rdata` is 0 whenever `bus_rd` is low, and a read of address 3 returns 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Byte location: 0 data low, 1 data high, 2 counter low, 3 reserved |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of `bus_rd` |
| split_mode | input | 1 | 1: halves written independently; 0: paired word writes |
| capture_mode | input | 1 | 1: capture use; 0: compare use |
| cap_strobe | input | 1 | Capture request, one cycle |
| cnt_value | input | 16 | Counter value to capture or read |
| cmp_value | output | 16 | Current word |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle, since a bus master issues one access per cycle. One property checks this assumption. The one-cycle-before checks of capture and split writes also assume that `capture_mode` and `split_mode` are steady around each strobe. The bench changes the mode inputs only while no strobe is active. It drives every strobe for exactly one cycle, between falling edges, so each access falls inside these assumptions.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   typedef enum logic [1:0] {
      LOC_DATA_LO = 2'd0,
      LOC_DATA_HI = 2'd1,
      LOC_CNT_LO  = 2'd2,
      LOC_RSVD    = 2'd3
   } ccr_loc_e;
endpackage

// File: rtl/ccr_wr_stage.sv
module ccr_wr_stage #(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              split_mode,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [WORD_W-1:0] cur_word,
   output logic              load,
   output logic [WORD_W-1:0] next_word
);
   logic [BYTE_W-1:0] staged_hi;

   // staging latch only used in paired mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    staged_hi <= '0;
      else if (wr_hi && !split_mode) staged_hi <= wdata;
   end

   always_comb begin
      load      = wr_lo || (split_mode && wr_hi);
      next_word = {staged_hi, wdata};
      if (split_mode) begin
         if (wr_hi) next_word = {wdata, cur_word[BYTE_W-1:0]};
         else       next_word = {cur_word[WORD_W-1:BYTE_W], wdata};
      end
   end
endmodule

// File: rtl/ccr_rd_stage.sv
module ccr_rd_stage
   import ccr_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [WORD_W-1:0] word,
   input  logic [WORD_W-1:0] cnt,
   output logic [BYTE_W-1:0] rdata
);
   logic [BYTE_W-1:0] held_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_hi <= '0;
      else if (rd_en) begin
         if (addr == LOC_DATA_LO)     held_hi <= word[WORD_W-1:BYTE_W];
         else if (addr == LOC_CNT_LO) held_hi <= cnt[WORD_W-1:BYTE_W];
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            LOC_DATA_LO: rdata = word[BYTE_W-1:0];
            LOC_DATA_HI: rdata = held_hi;
            LOC_CNT_LO:  rdata = cnt[BYTE_W-1:0];
            default:     rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ccr_byte_reg.sv
module ccr_byte_reg
   import ccr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter bit HAS_CAPTURE = 1'b1,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              split_mode,
   input  logic              capture_mode,
   input  logic              cap_strobe,
   input  logic [WORD_W-1:0] cnt_value,
   output logic [WORD_W-1:0] cmp_value
);
   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("ccr_byte_reg: BYTE_W must be at least 2");
      end
   endgenerate

   logic              wr_lo, wr_hi, wr_load, cap_hit;
   logic [WORD_W-1:0] wr_word, word_q;

   assign wr_lo = bus_wr && (bus_addr == LOC_DATA_LO);
   assign wr_hi = bus_wr && (bus_addr == LOC_DATA_HI);

   generate
      if (HAS_CAPTURE) begin : g_cap
         assign cap_hit = capture_mode && cap_strobe;
      end else begin : g_nocap
         assign cap_hit = 1'b0;
      end
   endgenerate

   ccr_wr_stage #(.BYTE_W(BYTE_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .split_mode(split_mode), .wdata(bus_wdata), .cur_word(word_q),
      .load(wr_load), .next_word(wr_word)
   );

   // capture outranks a software update in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (cap_hit) word_q <= cnt_value;
      else if (wr_load) word_q <= wr_word;
   end

   ccr_rd_stage #(.BYTE_W(BYTE_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .addr(bus_addr),
      .word(word_q), .cnt(cnt_value), .rdata(bus_rdata)
   );

   assign cmp_value = word_q;
endmodule

// File: rtl/ccr_byte_reg_chk.sv
module ccr_byte_reg_chk #(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic [BYTE_W-1:0] bus_rdata,
   input logic              split_mode,
   input logic              capture_mode,
   input logic              cap_strobe,
   input logic [WORD_W-1:0] cnt_value,
   input logic [WORD_W-1:0] cmp_value
);
   logic cap_now;
   assign cap_now = capture_mode && cap_strobe;

   p_one_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   p_hi_staged_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd1 && !split_mode && !cap_now) |=> $stable(cmp_value));

   p_low_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd0) |-> bus_rdata == cmp_value[BYTE_W-1:0]);

   p_split_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0 && split_mode && !cap_now) |=>
      (cmp_value[BYTE_W-1:0] == $past(bus_wdata) &&
       cmp_value[WORD_W-1:BYTE_W] == $past(cmp_value[WORD_W-1:BYTE_W])));

   p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_now |=> cmp_value == $past(cnt_value));   // also covers R10

   p_cmp_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_strobe && !capture_mode && !bus_wr) |=> $stable(cmp_value));

   p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);
endmodule

bind ccr_byte_reg ccr_byte_reg_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/ccr_byte_reg_test.sv
`timescale 1ns/1ps
module ccr_byte_reg_test;
   logic        clk = 0, rst_n = 0;
   logic [1:0]  bus_addr = 0;
   logic        bus_wr = 0, bus_rd = 0, split_mode = 0, capture_mode = 0, cap_strobe = 0;
   logic [7:0]  bus_wdata = 0, bus_rdata;
   logic [15:0] cnt_value = 0, cmp_value;
   int          n_chk = 0, n_bad = 0;
   logic [7:0]  rd_byte;

   always #5 clk = ~clk;

   ccr_byte_reg uut (.*);

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d, logic strobe = 0);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1; cap_strobe = strobe;
      @(negedge clk);
      bus_wr = 0; cap_strobe = 0;
   endtask

   task automatic rd(logic [1:0] a);
      @(negedge clk);
      bus_addr = a; bus_rd = 1;
      #1 rd_byte = bus_rdata;
      @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic word_wr(logic [15:0] w);
      wr(2'd1, w[15:8]); wr(2'd0, w[7:0]);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] w, prev;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 word", cmp_value, 16'h0);
      rd(2'd1); check("R1 hold", {8'h0, rd_byte}, 16'h0);
      wr(2'd0, 8'h5A); check("R1 stage", cmp_value, 16'h005A);

      // R2 paired writes sweep
      for (int i = 0; i < 256; i++) begin
         prev = cmp_value;
         w = 16'(i * 16'd1031 + 16'd7) ^ 16'(i << 9);
         wr(2'd1, w[15:8]); check("R2 hi staged", cmp_value, prev);
         wr(2'd0, w[7:0]);  check("R2 word", cmp_value, w);
      end

      // R3 dangling high write
      word_wr(16'h1234);
      wr(2'd1, 8'hAB);
      repeat (20) @(negedge clk);
      check("R3 dangling", cmp_value, 16'h1234);

      // R4 / R5 read ordering sweep
      for (int i = 0; i < 64; i++) begin
         w = 16'(i * 16'd4099 + 16'd3);
         word_wr(w);
         rd(2'd0); check("R4 low live", {8'h0, rd_byte}, {8'h0, w[7:0]});
         word_wr(~w);
         rd(2'd1); check("R5 held hi", {8'h0, rd_byte}, {8'h0, w[15:8]});
      end

      // R6 interleaved high write
      wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd0, 8'h33);
      check("R6 latest hi", cmp_value, 16'h2233);

      // R7 counter read and repeated low read reload the hold
      cnt_value = 16'hC3D4;
      rd(2'd0);
      rd(2'd2); check("R7 cnt lo", {8'h0, rd_byte}, 16'h00D4);
      rd(2'd1); check("R7 cnt hi held", {8'h0, rd_byte}, 16'h00C3);
      rd(2'd0); rd(2'd1); check("R7 reload", {8'h0, rd_byte}, 16'h0022);

      // R8 split writes, staging latch untouched
      wr(2'd1, 8'h77);               // staged 0x77 in word mode
      split_mode = 1;
      for (int i = 0; i < 32; i++) begin
         prev = cmp_value;
         wr(2'd0, 8'(i * 37));
         check("R8 lo only", cmp_value, {prev[15:8], 8'(i * 37)});
         wr(2'd1, 8'(i * 91 + 5));
         check("R8 hi only", cmp_value, {8'(i * 91 + 5), 8'(i * 37)});
      end
      rd(2'd0); rd(2'd1); check("R8 split read hold", {8'h0, rd_byte}, {8'h0, cmp_value[15:8]});
      split_mode = 0;
      wr(2'd0, 8'h99); check("R8 latch kept", cmp_value, 16'h7799);

      // R11 idle data, reserved reads, writes to read-only spots
      @(negedge clk); check("R11 idle", {8'h0, bus_rdata}, 16'h0);
      rd(2'd3); check("R11 rsvd", {8'h0, rd_byte}, 16'h0);
      wr(2'd2, 8'hEE); wr(2'd3, 8'hEF); check("R11 no write", cmp_value, 16'h7799);

      // R9 capture vs compare use
      cnt_value = 16'hBEEF;
      @(negedge clk); cap_strobe = 1; @(negedge clk); cap_strobe = 0;
      check("R9 compare ignores", cmp_value, 16'h7799);
      capture_mode = 1;
      @(negedge clk); cap_strobe = 1; @(negedge clk); cap_strobe = 0;
      check("R9 capture", cmp_value, 16'hBEEF);

      // R10 capture beats completing write
      cnt_value = 16'h4242;
      wr(2'd1, 8'h01); wr(2'd0, 8'h02, 1'b1);
      check("R10 capture wins", cmp_value, 16'h4242);
      wr(2'd1, 8'h05); wr(2'd0, 8'h06);
      check("R10 write in capture use", cmp_value, 16'h0506);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule